// File: doc/BRIEF.md
# Fully associative address translation buffer

The block caches a small set of recent virtual-to-physical page mappings. A 32-bit virtual address splits into a 20-bit virtual page number (bits 31:12) and a 12-bit page offset (bits 11:0). The page number is compared against every valid entry at once. On a match the block returns, in the same cycle, a 30-bit physical address. Its upper 18 bits (29:12) are the stored physical page number and its low 12 bits are the offset, copied unchanged. It also reports the index of the matching entry, that entry's reference and dirty state as they stood before the access, a permission fault and a multiple-match error.

On a miss, an outside agent (a table walker, for example) supplies the translation through a refill port. The block stores it in the lowest-numbered invalid entry if there is one, and otherwise in the least recently used entry. A flush input invalidates every entry.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and the LRU order runs from entry 0 (least recent) to entry N-1 (most recent).
- R2: With `lookup_valid_i` high, `hit_o` is 1 in the same cycle if a valid entry holds the page number in `lookup_vaddr_i[31:12]`, and `miss_o` is 1 otherwise. With `lookup_valid_i` low, both are 0.
- R3: On a hit, `paddr_o[29:12]` is the matched entry's physical page number and `paddr_o[11:0]` equals `lookup_vaddr_i[11:0]`. `hit_idx_o` gives the matched entry's index.
- R4: A refill writes the lowest-numbered invalid entry if one exists. Otherwise it writes the least recently used entry. The written entry is valid from the next cycle, with its reference and dirty bits cleared.
- R5: A refill, or a lookup hit in a cycle with no refill and no flush, makes that entry the most recently used. Misses leave the order unchanged.
- R6: `hit_ref_o` shows the matched entry's reference bit before the access. Every hit that updates state sets that bit.
- R7: `hit_dirty_o` shows the matched entry's dirty bit before the access. A write hit (`lookup_write_i`=1) that has permission sets the dirty bit.
- R8: Permission bit 0 allows reads and bit 1 allows writes. A hit whose access type is not allowed raises `perm_fault_o` together with `hit_o`, and it sets no dirty bit.
- R9: When two or more valid entries match, `multi_hit_o` is 1 and the lowest-numbered matching entry supplies the index and the translation.
- R10: `flush_i` invalidates every entry from the next cycle. A refill in the same cycle as a flush is discarded.
- R11: A lookup in a cycle that carries a refill or a flush still reports its result, but it does not change the reference bit, the dirty bit or the LRU order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vaddr_i | input | 32 | Virtual address |
| lookup_write_i | input | 1 | Lookup is a write access |
| hit_o | output | 1 | Translation found |
| miss_o | output | 1 | Lookup found no translation |
| paddr_o | output | 30 | Physical address (page number is 0 on a miss) |
| hit_idx_o | output | 3 | Index of the matched entry |
| hit_ref_o | output | 1 | Reference bit of the matched entry before the access |
| hit_dirty_o | output | 1 | Dirty bit of the matched entry before the access |
| perm_fault_o | output | 1 | Access type not allowed by the entry |
| multi_hit_o | output | 1 | More than one entry matched |
| refill_valid_i | input | 1 | Write a translation |
| refill_vpn_i | input | 20 | Virtual page number to store |
| refill_ppn_i | input | 18 | Physical page number to store |
| refill_perm_i | input | 2 | Permissions: bit 0 read, bit 1 write |
| flush_i | input | 1 | Invalidate all entries |

## Verification
On every cycle the assertions check four things:
- hit and miss never occur together, and fault and multiple-match are reported only with a hit;
- a flush leaves no valid entry, and a refill leaves its target valid;
- a permitted write hit leaves the dirty bit set;
- the LRU order always has exactly one victim, and that victim is never the entry just touched.

Only the bench scenarios can show the rest. That means the victim chosen after a given sequence of hits, the lowest-invalid fill rule after a flush, and the translated address values. It also covers the ordering of reference and dirty reports across successive accesses, the priority choice among duplicate matches, and the suppression of lookup updates during a refill or flush cycle.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 30;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PERM_W = 2;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam import tlb_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]        vpn_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    multi_o
);
  logic [N-1:0] match;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid_i[i] && (tag_i[i] == vpn_i);
  end

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o   = |match;
  assign multi_o = |(match & (match - N'(1)));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  localparam logic [IDX_W-1:0] MRU = IDX_W'(N - 1);

  // rank 0 = least recent, N-1 = most recent
  logic [IDX_W-1:0] rank_q [N];
  logic [N-1:0]     is_lru;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int j = 0; j < N; j++) begin
        if (IDX_W'(j) == touch_idx_i)          rank_q[j] <= MRU;
        else if (rank_q[j] > rank_q[touch_idx_i]) rank_q[j] <= rank_q[j] - 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lru
    assign is_lru[i] = (rank_q[i] == '0);
  end

  always_comb begin
    victim_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (is_lru[i]) victim_o = IDX_W'(i);
    end
  end

  a_r5_one_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_lru) == 1);

  a_r5_touch_not_victim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> victim_o != $past(touch_idx_i));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa import tlb_pkg::*; #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VA_W-1:0]   lookup_vaddr_i,
  input  logic              lookup_write_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic              hit_ref_o,
  output logic              hit_dirty_o,
  output logic              perm_fault_o,
  output logic              multi_hit_o,
  input  logic              refill_valid_i,
  input  logic [VPN_W-1:0]  refill_vpn_i,
  input  logic [PPN_W-1:0]  refill_ppn_i,
  input  logic [PERM_W-1:0] refill_perm_i,
  input  logic              flush_i
);
  logic [N-1:0]             valid_q, ref_q, dirty_q;
  logic [N-1:0][VPN_W-1:0]  vpn_q;
  logic [N-1:0][PPN_W-1:0]  ppn_q;
  logic [N-1:0][PERM_W-1:0] perm_q;

  logic [VPN_W-1:0] lk_vpn;
  logic             cam_hit, cam_multi, allow;
  logic [IDX_W-1:0] cam_idx, victim, free_idx, fill_idx, touch_idx;
  logic             any_free, do_fill, do_upd, touch;

  assign lk_vpn = lookup_vaddr_i[VA_W-1:OFF_W];

  tlb_cam #(.N(N), .IDX_W(IDX_W)) u_cam (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .vpn_i   (lk_vpn),
    .hit_o   (cam_hit),
    .idx_o   (cam_idx),
    .multi_o (cam_multi)
  );

  tlb_lru #(.N(N), .IDX_W(IDX_W)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .victim_o    (victim)
  );

  assign hit_o        = lookup_valid_i & cam_hit;
  assign miss_o       = lookup_valid_i & ~cam_hit;
  assign multi_hit_o  = lookup_valid_i & cam_multi;
  assign hit_idx_o    = hit_o ? cam_idx : '0;
  assign allow        = lookup_write_i ? perm_q[cam_idx][PERM_WR] : perm_q[cam_idx][PERM_RD];
  assign perm_fault_o = hit_o & ~allow;
  assign hit_ref_o    = hit_o & ref_q[cam_idx];
  assign hit_dirty_o  = hit_o & dirty_q[cam_idx];
  assign paddr_o      = {(hit_o ? ppn_q[cam_idx] : {PPN_W{1'b0}}), lookup_vaddr_i[OFF_W-1:0]};

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign fill_idx  = any_free ? free_idx : victim;
  assign do_fill   = refill_valid_i & ~flush_i;
  assign do_upd    = hit_o & ~refill_valid_i & ~flush_i;
  assign touch     = do_fill | do_upd;
  assign touch_idx = do_fill ? fill_idx : cam_idx;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        ref_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        ppn_q[i]   <= '0;
        perm_q[i]  <= '0;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
      end else if (do_fill && fill_idx == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        ref_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= refill_vpn_i;
        ppn_q[i]   <= refill_ppn_i;
        perm_q[i]  <= refill_perm_i;
      end else if (do_upd && cam_idx == IDX_W'(i)) begin
        ref_q[i] <= 1'b1;
        if (lookup_write_i && allow) dirty_q[i] <= 1'b1;
      end
    end
  end

  a_r2_hit_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  a_r8_fault_with_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_fault_o |-> hit_o);

  a_r9_multi_with_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o);

  a_r10_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);

  a_r4_fill_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_valid_i && !flush_i) |=> valid_q[$past(fill_idx)]);

  a_r7_dirty_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && lookup_write_i && !perm_fault_o && !refill_valid_i && !flush_i)
      |=> dirty_q[$past(hit_idx_o)]);
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_valid_i = 1'b0;
  logic [31:0] lookup_vaddr_i = '0;
  logic        lookup_write_i = 1'b0;
  logic        hit_o, miss_o, hit_ref_o, hit_dirty_o, perm_fault_o, multi_hit_o;
  logic [29:0] paddr_o;
  logic [2:0]  hit_idx_o;
  logic        refill_valid_i = 1'b0;
  logic [19:0] refill_vpn_i = '0;
  logic [17:0] refill_ppn_i = '0;
  logic [1:0]  refill_perm_i = '0;
  logic        flush_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // captured outputs
  logic        c_hit, c_miss, c_ref, c_dirty, c_fault, c_multi;
  logic [29:0] c_pa;
  logic [2:0]  c_idx;

  always #5 clk_i = ~clk_i;

  tlb_fa #(.N(8)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture();
    c_hit = hit_o; c_miss = miss_o; c_ref = hit_ref_o; c_dirty = hit_dirty_o;
    c_fault = perm_fault_o; c_multi = multi_hit_o; c_pa = paddr_o; c_idx = hit_idx_o;
  endtask

  task automatic lookup(logic [31:0] va, logic wr);
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_vaddr_i = va; lookup_write_i = wr;
    #1 capture();
    @(posedge clk_i);
    #1 lookup_valid_i = 1'b0; lookup_write_i = 1'b0;
  endtask

  task automatic refill(logic [19:0] vpn, logic [17:0] ppn, logic [1:0] perm);
    @(negedge clk_i);
    refill_valid_i = 1'b1; refill_vpn_i = vpn; refill_ppn_i = ppn; refill_perm_i = perm;
    @(posedge clk_i);
    #1 refill_valid_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk_i);
    flush_i = 1'b1;
    @(posedge clk_i);
    #1 flush_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    #1 chk("R2 idle hit", hit_o, 0);
    chk("R2 idle miss", miss_o, 0);
    lookup(32'h0010_0abc, 0);
    chk("R1 reset miss", c_miss, 1);
    chk("R1 reset no hit", c_hit, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) refill(20'h00100 + 20'(i), 18'h200 + 18'(i), 2'b11);
    for (int i = 0; i < 8; i++) begin
      logic [11:0] off = 12'h5a5 ^ 12'(i * 37);
      lookup({20'h00100 + 20'(i), off}, 0);
      chk("R2 hit", c_hit, 1);
      chk("R4 fill order idx", c_idx, i);
      chk("R3 paddr", c_pa, {18'h200 + 18'(i), off});
      chk("R6 ref before first hit", c_ref, 0);
    end
    lookup(32'h0010_0000, 0);
    chk("R6 ref after hit", c_ref, 1);
  endtask

  task automatic t_lru();
    // order now 1..7,0 : entry 1 is LRU
    refill(20'h00300, 18'h3ff, 2'b11);
    lookup(32'h0030_0123, 0);
    chk("R5 lru victim idx", c_idx, 1);
    chk("R3 paddr new", c_pa, {18'h3ff, 12'h123});
    lookup(32'h0010_1000, 0);
    chk("R5 evicted misses", c_miss, 1);
  endtask

  task automatic t_dirty();
    lookup(32'h0010_2000, 1);
    chk("R7 dirty before write", c_dirty, 0);
    chk("R8 no fault rw", c_fault, 0);
    lookup(32'h0010_2000, 0);
    chk("R7 dirty after write", c_dirty, 1);
    // order 3..7,0,1,2 : victim 3
    refill(20'h00400, 18'h044, 2'b11);
    lookup(32'h0040_0000, 0);
    chk("R5 victim after hits", c_idx, 3);
  endtask

  task automatic t_flush_perm();
    flush();
    lookup(32'h0010_0000, 0);
    chk("R10 flushed miss a", c_miss, 1);
    lookup(32'h0030_0000, 0);
    chk("R10 flushed miss b", c_miss, 1);
    refill(20'h00500, 18'h050, 2'b01);
    refill(20'h00501, 18'h051, 2'b10);
    lookup(32'h0050_0000, 1);
    chk("R4 lowest invalid 0", c_idx, 0);
    chk("R8 write fault", c_fault, 1);
    chk("R8 fault with hit", c_hit, 1);
    lookup(32'h0050_0000, 0);
    chk("R8 read ok", c_fault, 0);
    chk("R8 no dirty on fault", c_dirty, 0);
    lookup(32'h0050_1000, 0);
    chk("R4 lowest invalid 1", c_idx, 1);
    chk("R8 read fault", c_fault, 1);
    lookup(32'h0050_1000, 1);
    chk("R8 write ok", c_fault, 0);
  endtask

  task automatic t_flush_refill();
    @(negedge clk_i);
    flush_i = 1'b1; refill_valid_i = 1'b1; refill_vpn_i = 20'h00600; refill_ppn_i = 18'h66;
    refill_perm_i = 2'b11;
    @(posedge clk_i);
    #1 flush_i = 1'b0; refill_valid_i = 1'b0;
    lookup(32'h0060_0000, 0);
    chk("R10 refill dropped", c_miss, 1);
  endtask

  task automatic t_multi();
    refill(20'h00700, 18'h011, 2'b11);
    refill(20'h00700, 18'h022, 2'b11);
    lookup(32'h0070_0abc, 0);
    chk("R9 multi flag", c_multi, 1);
    chk("R9 lowest idx", c_idx, 0);
    chk("R9 lowest ppn", c_pa, {18'h011, 12'habc});
  endtask

  task automatic t_suppress();
    refill(20'h00800, 18'h080, 2'b11);
    @(negedge clk_i);
    lookup_valid_i = 1'b1; lookup_vaddr_i = 32'h0080_0000; lookup_write_i = 1'b1;
    refill_valid_i = 1'b1; refill_vpn_i = 20'h00801; refill_ppn_i = 18'h081;
    #1 chk("R11 concurrent hit", hit_o, 1);
    @(posedge clk_i);
    #1 lookup_valid_i = 1'b0; lookup_write_i = 1'b0; refill_valid_i = 1'b0;
    lookup(32'h0080_0000, 0);
    chk("R11 ref unchanged", c_ref, 0);
    chk("R11 dirty unchanged", c_dirty, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_fill();
    t_lru();
    t_dirty();
    t_flush_perm();
    t_flush_refill();
    t_multi();
    t_suppress();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule